// File: doc/BRIEF.md
# I2C Master Clock Generator with Clock-Stretch Wait

This block is the timing and command core of an I2C bus master. An 8-bit down-counter paces every half-period of the serial clock. Each bus event is built from a short list of half-period segments. In each segment the master either pulls SCL low or lets it float, and either pulls SDA low or lets it float. The supported events are a start, a repeated start, a stop, a byte transmit, a byte receive and an acknowledge bit. Both lines are open-drain: the block only drives low-enables. It samples the SCL pin back through a synchronizer, so it sees when a slave keeps the clock low.

Software uses a four-address write port. Writing the transmit buffer while the bus is owned and waiting sends the byte. A command write starts the other events. A write made while an event is running has no effect. If that write targets the transmit buffer, it also raises a sticky collision flag.

Top module: `i2c_sclgen_core`

## Requirements
- R1: After reset, both drive-low outputs are 0, `busy` is 0, `wcol` is 0, `tx_buf` is 0 and `brg_count` is 0.
- R2: A running counter loses exactly one count every second clock. Phase is counted from reset over a four-phase cycle, and the count steps on phases 1 and 3.
- R3: When the counter reaches 0 it stays at 0 until the next reload. It never wraps.
- R4: In a segment where SCL is released, the counter is frozen while the SCL pin is sampled low. It reloads on the first high sample taken through a two-stage synchronizer. The SCL high time after a slave lets go is therefore at least twice the effective reload value in clocks.
- R5: The effective reload value is the host value (address 2), except that 0, 1 and 2 are raised to 3.
- R6: A transmit-buffer write (address 0) while an event runs sets `wcol` and leaves `tx_buf` unchanged. Otherwise it loads `tx_buf`. When the bus is held, it also starts a nine-bit transmit: eight data bits MSB first, where SDA is driven low for a 0, followed by a released acknowledge bit.
- R7: Command writes go to address 1: bit0 start, bit1 repeated start, bit2 stop, bit3 receive, bit4 acknowledge. When the bus is idle, only bit0 has an effect. When the bus is held, the lowest set bit among bits 1 to 4 wins. While an event runs, command writes are ignored.
- R8: `wcol` stays set until a write to address 3 with bit0 equal to 0.
- R9: `busy` rises the clock after a command is accepted. It falls only when a stop completes, and at that point SCL and SDA are both released.
- R10: Each event is a fixed series of segments, given as (SCL, SDA). Start is (released, low), (low, low). Repeated start is (low, released), (released, released), (released, low), (low, low). Stop is (low, low), (released, low), (released, released). After every event except stop, the bus is held with SCL driven low.
- R11: Receive runs eight clock pulses with SDA released. Acknowledge runs one clock pulse with SDA driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | 0 transmit buffer, 1 command, 2 reload, 3 status |
| host_wdata | input | 8 | Host write data |
| scl_in | input | 1 | Sampled SCL pin level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| tx_buf | output | 8 | Transmit buffer contents |
| wcol | output | 1 | Sticky write-collision flag |
| busy | output | 1 | Bus owned by this master |
| brg_count | output | 8 | Current counter value |

## Verification
The clock engine is run with the SCL pin following the master alone and with a slave holding SCL low for many clocks after a release. This separates a counter that freezes and reloads on the synchronized high level from one that keeps running or reloads early. Reload values of 0, 6 and 20 separate the raised floor from the plain value and show the two-clock step rate. Host writes are issued in every bus state (idle, held and mid-event), which separates accepted, ignored and collision-flagged writes.

// File: rtl/i2c_sclgen_pkg.sv
// Shared types and constants for the I2C clock generator.
// Assumes: a single host write port with a 2-bit address.
package i2c_sclgen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HOLD, ST_START, ST_RSTART, ST_STOP, ST_XMIT, ST_RECV, ST_ACK
    } seq_state_e;

    localparam logic [1:0] ADDR_TX   = 2'd0;
    localparam logic [1:0] ADDR_CMD  = 2'd1;
    localparam logic [1:0] ADDR_RLD  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int CMD_START  = 0;
    localparam int CMD_RSTART = 1;
    localparam int CMD_STOP   = 2;
    localparam int CMD_RECV   = 3;
    localparam int CMD_ACK    = 4;
    localparam int CMD_W      = 5;

    // One half-period segment of a bus event.
    typedef struct packed {
        logic last;
        logic scl_rel;
        logic sda_low;
    } seg_t;

endpackage

// File: rtl/sclgen_sync.sv
// Multi-stage synchronizer for the sampled SCL pin.
// Assumes: STAGES >= 2; the idle level of the bus is high, so it resets to 1.
module sclgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // shift the pin level through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sclgen_brg.sv
// Down-counting half-period timer with clock-stretch wait.
// A segment start with SCL driven low loads the counter at once. A segment
// start with SCL released arms a wait: the count is frozen until the
// synchronized SCL is high, then it reloads. The counter steps on tick and
// holds at zero.
// Assumes: seg_start is never raised while the wait is armed.
module sclgen_brg #(
    parameter int CNT_W   = 8,
    parameter int CNT_MIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             seg_start,
    input  logic             seg_rel,
    input  logic             scl_hi,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(CNT_MIN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_reload;
    logic             wait_q;

    // raise too-small reload values to the legal floor
    assign eff_reload = (reload < MIN_V) ? MIN_V : reload;

    // load, wait for SCL high, or count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wait_q <= 1'b0;
        end else if (seg_start) begin
            if (seg_rel) begin
                wait_q <= 1'b1;
            end else begin
                cnt_q  <= eff_reload;
                wait_q <= 1'b0;
            end
        end else if (wait_q && scl_hi) begin
            cnt_q  <= eff_reload;
            wait_q <= 1'b0;
        end else if (tick && !wait_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign expired = !wait_q && (cnt_q == '0);

    // R3: a zero count stays zero unless a reload event occurs
    assert_zero_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !seg_start && !(wait_q && scl_hi)) |=> (cnt_q == '0));

    // R4: frozen while waiting and SCL still sampled low
    assert_frozen_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_q && !scl_hi && !seg_start) |=> $stable(cnt_q));

    // R5: every load lands at or above the floor
    assert_reload_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_start && !seg_rel) |=> (cnt_q >= MIN_V));
endmodule

// File: rtl/sclgen_seq.sv
// Event sequencer. It accepts commands while idle or holding the bus, then
// steps through the half-period segments of the event, one per counter
// expiry, and drives the two open-drain low-enables.
// Assumes: tx_data stays stable while a transmit runs.
module sclgen_seq
    import i2c_sclgen_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expired,
    input  logic              tx_wr,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] tx_data,
    output logic              scl_lo,
    output logic              sda_lo,
    output logic              busy,
    output logic              active,
    output logic              seg_start,
    output logic              seg_rel
);
    localparam int XMIT_LAST = 2 * (DATA_W + 1) - 1;
    localparam int RECV_LAST = 2 * DATA_W - 1;
    localparam int IDX_W     = $clog2(XMIT_LAST + 1);
    localparam int BIT_W     = $clog2(DATA_W);

    seq_state_e       state_q, ent_state;
    logic [IDX_W-1:0] idx_q, ent_idx;
    logic             scl_lo_q, sda_lo_q;
    logic             enter, finish;
    seg_t             cur_seg, ent_seg;

    // segment table, computed per event and index
    function automatic seg_t seg_of(input seq_state_e st,
                                    input logic [IDX_W-1:0] idx,
                                    input logic [DATA_W-1:0] d);
        seg_t             s;
        logic [IDX_W-2:0] bitn;
        logic [BIT_W-1:0] pos;
        s    = '0;
        bitn = idx[IDX_W-1:1];
        pos  = BIT_W'(DATA_W - 1) - bitn[BIT_W-1:0];
        case (st)
            ST_START: begin
                s.scl_rel = (idx == '0);
                s.sda_low = 1'b1;
                s.last    = (idx == IDX_W'(1));
            end
            ST_RSTART: begin
                s.scl_rel = (idx == IDX_W'(1)) || (idx == IDX_W'(2));
                s.sda_low = (idx >= IDX_W'(2));
                s.last    = (idx == IDX_W'(3));
            end
            ST_STOP: begin
                s.scl_rel = (idx != '0);
                s.sda_low = (idx != IDX_W'(2));
                s.last    = (idx == IDX_W'(2));
            end
            ST_XMIT: begin
                s.scl_rel = idx[0];
                s.sda_low = (int'(bitn) < DATA_W) ? !d[pos] : 1'b0;
                s.last    = (idx == IDX_W'(XMIT_LAST));
            end
            ST_RECV: begin
                s.scl_rel = idx[0];
                s.last    = (idx == IDX_W'(RECV_LAST));
            end
            ST_ACK: begin
                s.scl_rel = idx[0];
                s.sda_low = 1'b1;
                s.last    = (idx == IDX_W'(1));
            end
            default: s = '0;
        endcase
        return s;
    endfunction

    assign cur_seg = seg_of(state_q, idx_q, tx_data);

    // decide whether a new segment begins or the event finishes
    always_comb begin
        enter     = 1'b0;
        finish    = 1'b0;
        ent_state = state_q;
        ent_idx   = idx_q + 1'b1;
        case (state_q)
            ST_IDLE: begin
                if (cmd_wr && cmd[CMD_START]) begin
                    enter = 1'b1; ent_state = ST_START; ent_idx = '0;
                end
            end
            ST_HOLD: begin
                ent_idx = '0;
                if (tx_wr) begin
                    enter = 1'b1; ent_state = ST_XMIT;
                end else if (cmd_wr) begin
                    if (cmd[CMD_RSTART]) begin
                        enter = 1'b1; ent_state = ST_RSTART;
                    end else if (cmd[CMD_STOP]) begin
                        enter = 1'b1; ent_state = ST_STOP;
                    end else if (cmd[CMD_RECV]) begin
                        enter = 1'b1; ent_state = ST_RECV;
                    end else if (cmd[CMD_ACK]) begin
                        enter = 1'b1; ent_state = ST_ACK;
                    end
                end
            end
            default: begin
                if (expired) begin
                    if (cur_seg.last) finish = 1'b1;
                    else              enter  = 1'b1;
                end
            end
        endcase
    end

    assign ent_seg   = seg_of(ent_state, ent_idx, tx_data);
    assign seg_start = enter;
    assign seg_rel   = ent_seg.scl_rel;

    // advance state and register the line drives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            scl_lo_q <= 1'b0;
            sda_lo_q <= 1'b0;
        end else if (enter) begin
            state_q  <= ent_state;
            idx_q    <= ent_idx;
            scl_lo_q <= !ent_seg.scl_rel;
            sda_lo_q <= ent_seg.sda_low;
        end else if (finish) begin
            if (state_q == ST_STOP) begin
                state_q  <= ST_IDLE;
                scl_lo_q <= 1'b0;
                sda_lo_q <= 1'b0;
            end else begin
                state_q  <= ST_HOLD;
                scl_lo_q <= 1'b1;
            end
        end
    end

    assign scl_lo = scl_lo_q;
    assign sda_lo = sda_lo_q;
    assign busy   = (state_q != ST_IDLE);
    assign active = busy && (state_q != ST_HOLD);

    // R7: a command write during a running event cannot change the event
    assert_cmd_ignored_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && active && !expired) |=> $stable(state_q));

    // R9: the bus is fully released whenever ownership ends
    assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!scl_lo_q && !sda_lo_q));
endmodule

// File: rtl/i2c_sclgen_core.sv
// Top of the I2C master clock generator. Holds the host-visible registers
// (transmit buffer, reload value, collision flag) and the phase divider,
// and ties the synchronizer, counter and sequencer together.
// Assumes: PHASES is a power of two >= 2; the counter steps on odd phases.
module i2c_sclgen_core
    import i2c_sclgen_pkg::*;
#(
    parameter int          CNT_W       = 8,
    parameter int          CNT_MIN     = 3,
    parameter int          SYNC_STAGES = 2,
    parameter int          PHASES      = 4,
    parameter logic [7:0]  RELOAD_INIT = 8'd10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [1:0]       host_addr,
    input  logic [7:0]       host_wdata,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic [7:0]       tx_buf,
    output logic             wcol,
    output logic             busy,
    output logic [CNT_W-1:0] brg_count
);
    localparam int PH_W = $clog2(PHASES);

    logic [PH_W-1:0]  ph_q;
    logic [7:0]       tx_buf_q, tx_view;
    logic [CNT_W-1:0] reload_q;
    logic             wcol_q;
    logic             scl_hi, expired, seg_start, seg_rel, active;
    logic             tx_wr, cmd_wr, rld_wr, stat_wr;

    assign tx_wr   = host_wr && (host_addr == ADDR_TX);
    assign cmd_wr  = host_wr && (host_addr == ADDR_CMD);
    assign rld_wr  = host_wr && (host_addr == ADDR_RLD);
    assign stat_wr = host_wr && (host_addr == ADDR_STAT);

    // free-running phase divider
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_q + 1'b1;
    end

    // host registers: buffer, reload value, sticky collision flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf_q <= '0;
            reload_q <= CNT_W'(RELOAD_INIT);
            wcol_q   <= 1'b0;
        end else begin
            if (tx_wr) begin
                if (active) wcol_q   <= 1'b1;
                else        tx_buf_q <= host_wdata;
            end
            if (rld_wr) reload_q <= CNT_W'(host_wdata);
            if (stat_wr && !host_wdata[0]) wcol_q <= 1'b0;
        end
    end

    // the byte seen by the sequencer includes a write landing this cycle
    assign tx_view = (tx_wr && !active) ? host_wdata : tx_buf_q;

    sclgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_hi)
    );

    sclgen_brg #(.CNT_W(CNT_W), .CNT_MIN(CNT_MIN)) u_brg (
        .clk(clk), .rst_n(rst_n), .tick(ph_q[0]),
        .seg_start(seg_start), .seg_rel(seg_rel), .scl_hi(scl_hi),
        .reload(reload_q), .cnt(brg_count), .expired(expired)
    );

    sclgen_seq #(.DATA_W(8)) u_seq (
        .clk(clk), .rst_n(rst_n), .expired(expired),
        .tx_wr(tx_wr), .cmd_wr(cmd_wr), .cmd(host_wdata[CMD_W-1:0]),
        .tx_data(tx_view), .scl_lo(scl_drive_low), .sda_lo(sda_drive_low),
        .busy(busy), .active(active), .seg_start(seg_start), .seg_rel(seg_rel)
    );

    assign tx_buf = tx_buf_q;
    assign wcol   = wcol_q;

    // R6: buffer write during a running event flags and keeps the buffer
    assert_wcol_on_busy_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && active) |=> (wcol_q && $stable(tx_buf_q)));

    // R8: the flag stays set unless explicitly cleared
    assert_wcol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol_q && !(stat_wr && !host_wdata[0])) |=> wcol_q);
endmodule

// File: tb/i2c_sclgen_core_tb.sv
`timescale 1ns/1ps
module i2c_sclgen_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic       slave_hold = 1'b0;
    logic       scl_in;
    logic       scl_drive_low, sda_drive_low, wcol, busy;
    logic [7:0] tx_buf, brg_count;

    int n_checks = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_in = !(scl_drive_low || slave_hold);

    i2c_sclgen_core dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .tx_buf(tx_buf), .wcol(wcol),
        .busy(busy), .brg_count(brg_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_wait, m_s1, m_s2, m_ph, m_state, m_scl_lo, m_sda_lo;
    int m_wcol, m_buf, m_rld, m_after;
    int segq[$];

    function automatic int eff(input int r);
        return (r < 3) ? 3 : r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_wait = 0; m_s1 = 1; m_s2 = 1; m_ph = 0; m_state = 0;
            m_scl_lo = 0; m_sda_lo = 0; m_wcol = 0; m_buf = 0; m_rld = 10; m_after = 0;
            segq.delete();
        end else begin
            int o_cnt, o_wait, o_s2, o_state, o_eff, pin, sg;
            bit o_tick, launch;
            o_cnt = m_cnt; o_wait = m_wait; o_s2 = m_s2; o_state = m_state;
            o_tick = (m_ph % 2) == 1; o_eff = eff(m_rld);
            pin = (m_scl_lo != 0 || slave_hold) ? 0 : 1;
            launch = 1'b0;
            m_s2 = m_s1; m_s1 = pin;
            m_ph = (m_ph + 1) % 4;
            if (host_wr) begin
                case (host_addr)
                    2'd0: if (o_state == 2) m_wcol = 1;
                          else begin
                              m_buf = host_wdata;
                              if (o_state == 1) begin
                                  for (int b = 0; b < 8; b++) begin
                                      int v; v = host_wdata[7-b] ? 0 : 1;
                                      segq.push_back(v); segq.push_back(2 + v);
                                  end
                                  segq.push_back(0); segq.push_back(2);
                                  m_after = 1; launch = 1'b1;
                              end
                          end
                    2'd1: if (o_state == 0 && host_wdata[0]) begin
                              segq = '{3, 1}; m_after = 1; launch = 1'b1;
                          end else if (o_state == 1) begin
                              if (host_wdata[1]) begin segq = '{0, 2, 3, 1}; m_after = 1; launch = 1'b1; end
                              else if (host_wdata[2]) begin segq = '{1, 3, 2}; m_after = 0; launch = 1'b1; end
                              else if (host_wdata[3]) begin
                                  for (int b = 0; b < 8; b++) begin segq.push_back(0); segq.push_back(2); end
                                  m_after = 1; launch = 1'b1;
                              end
                              else if (host_wdata[4]) begin segq = '{1, 3}; m_after = 1; launch = 1'b1; end
                          end
                    2'd2: m_rld = host_wdata;
                    default: if (!host_wdata[0]) m_wcol = 0;
                endcase
            end
            if (o_state == 2 && o_cnt == 0 && o_wait == 0) begin
                if (segq.size() == 0) begin
                    if (m_after == 0) begin m_state = 0; m_scl_lo = 0; m_sda_lo = 0; end
                    else begin m_state = 1; m_scl_lo = 1; end
                end else launch = 1'b1;
            end
            if (launch) begin
                sg = segq.pop_front();
                m_state = 2;
                m_scl_lo = (sg / 2) ? 0 : 1;
                m_sda_lo = sg % 2;
                if (sg / 2) m_wait = 1;
                else begin m_cnt = o_eff; m_wait = 0; end
            end else if (o_wait != 0 && o_s2 != 0) begin
                m_cnt = o_eff; m_wait = 0;
            end else if (o_tick && o_cnt > 0 && o_wait == 0) begin
                m_cnt = o_cnt - 1;
            end
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done_flag) begin
            check(int'(brg_count) == m_cnt, "R2 count", brg_count, m_cnt);
            check(int'(scl_drive_low) == m_scl_lo, "R10 scl", scl_drive_low, m_scl_lo);
            check(int'(sda_drive_low) == m_sda_lo, "R10 sda", sda_drive_low, m_sda_lo);
            check(int'(busy) == (m_state != 0 ? 1 : 0), "R9 busy", busy, m_state != 0);
            check(int'(wcol) == m_wcol, "R8 wcol", wcol, m_wcol);
            check(int'(tx_buf) == m_buf, "R6 buffer", tx_buf, m_buf);
        end
    end

    // side monitors: peak count, SDA activity, bit capture, stop ordering
    int  trk_max = 0;
    bit  sda_seen_low = 1'b0;
    bit  cap_en = 1'b0;
    logic [8:0] cap_bits = '0;
    int  cap_n = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0;
    int  scl_at_sda_rise = -1;
    always @(negedge clk) begin
        if (int'(brg_count) > trk_max) trk_max = brg_count;
        if (sda_drive_low) sda_seen_low = 1'b1;
        if (cap_en && prev_scl && !scl_drive_low) begin
            cap_bits = {cap_bits[7:0], !sda_drive_low}; cap_n++;
        end
        if (prev_sda && !sda_drive_low) scl_at_sda_rise = scl_drive_low;
        prev_scl = scl_drive_low; prev_sda = sda_drive_low;
    end

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic wait_hold();
        int run = 0;
        for (int i = 0; i < 5000 && run < 3; i++) begin
            @(negedge clk);
            if (busy && scl_drive_low && brg_count == 0) run++; else run = 0;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic finish_test();
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        check(!scl_drive_low && !sda_drive_low, "R1 lines", scl_drive_low, 0);
        check(!busy && !wcol, "R1 flags", busy + wcol, 0);
        check(tx_buf == 0 && brg_count == 0, "R1 regs", tx_buf + brg_count, 0);
        chk_en = 1'b1;

        // R7: stop command while idle has no effect
        host_write(2'd1, 8'h04);
        repeat (5) @(negedge clk);
        check(!busy && !scl_drive_low, "R7 idle stop ignored", busy, 0);

        // R5: reload 0 acts as 3; R9: busy after accept
        host_write(2'd2, 8'h00);
        trk_max = 0;
        host_write(2'd1, 8'h01);
        check(busy == 1, "R9 busy on accept", busy, 1);
        wait_hold();
        check(trk_max == 3, "R5 floor", trk_max, 3);
        // R3: zero holds while the bus is held
        repeat (10) @(negedge clk);
        check(brg_count == 0, "R3 hold zero", brg_count, 0);

        // R10: stop, then lines released
        host_write(2'd2, 8'd6);
        host_write(2'd1, 8'h04);
        wait_idle();
        check(!scl_drive_low && !sda_drive_low, "R10 stop released", scl_drive_low + sda_drive_low, 0);
        check(scl_at_sda_rise == 0, "R10 sda released after scl", scl_at_sda_rise, 0);

        // R2: step rate with reload 20
        host_write(2'd2, 8'd20);
        host_write(2'd1, 8'h01);
        for (int i = 0; i < 500 && brg_count != 10; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(brg_count == 8, "R2 two clocks per step", brg_count, 8);
        wait_hold();

        // R6/R4: transmit with a stretched clock pulse
        host_write(2'd2, 8'd6);
        cap_en = 1'b1; cap_n = 0;
        host_write(2'd0, 8'hA5);
        begin
            int falls = 0; logic pv = 1'b1;
            for (int i = 0; i < 3000 && falls < 3; i++) begin
                @(negedge clk);
                if (pv && !scl_drive_low) falls++;
                pv = scl_drive_low;
            end
        end
        slave_hold = 1'b1;
        begin
            int c0, hi;
            repeat (3) @(negedge clk);
            c0 = brg_count;
            repeat (18) @(negedge clk);
            check(brg_count == c0, "R4 frozen while held", brg_count, c0);
            slave_hold = 1'b0;
            hi = 0;
            for (int i = 0; i < 500 && !scl_drive_low; i++) begin @(negedge clk); if (scl_in) hi++; end
            check(hi >= 12, "R4 high time after stretch", hi, 12);
        end
        host_write(2'd0, 8'h3C);
        check(wcol == 1 && tx_buf == 8'hA5, "R6 collision keeps buffer", tx_buf, 8'hA5);
        host_write(2'd1, 8'h04);
        wait_hold();
        cap_en = 1'b0;
        check(busy && scl_drive_low, "R7 stop during transmit ignored", busy, 1);
        check(cap_bits == {8'hA5, 1'b1} && cap_n == 9, "R6 bits msb first", cap_bits, {8'hA5, 1'b1});

        // R8: clear needs bit0 = 0
        host_write(2'd3, 8'h01);
        check(wcol == 1, "R8 kept on bit0=1", wcol, 1);
        host_write(2'd3, 8'h00);
        check(wcol == 0, "R8 cleared", wcol, 0);

        // R11: receive keeps SDA released, acknowledge drives it
        sda_seen_low = 1'b0;
        host_write(2'd1, 8'h08);
        wait_hold();
        check(!sda_seen_low, "R11 receive releases sda", sda_seen_low, 0);
        sda_seen_low = 1'b0;
        host_write(2'd1, 8'h10);
        wait_hold();
        check(sda_seen_low, "R11 ack drives sda", sda_seen_low, 1);

        // R10: repeated start ends holding with both low; then stop
        host_write(2'd1, 8'h02);
        wait_hold();
        check(busy && sda_drive_low, "R10 restart ends held", sda_drive_low, 1);
        host_write(2'd1, 8'h04);
        wait_idle();
        check(!busy && !scl_drive_low && !sda_drive_low, "R9 idle released", busy, 0);

        repeat (5) @(negedge clk);
        finish_test();
    end
endmodule